// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the processor-side engine that performs the entry steps of a vectored interrupt once the core has accepted one. On a one-cycle start pulse it captures the interrupting peripheral's 8-bit vector, the current program counter, the stack pointer, the page register that forms the upper half of the table address, and the current addressing-mode bit. It then writes a three-byte return frame below the 24-bit stack pointer through a byte-wide request/acknowledge memory port. It reads a two-byte handler address from the vector table and commits the new program counter, stack pointer and mode bit, signalling completion with a one-cycle done pulse.

The content of the return frame depends on the mode that was active when the interrupt was taken. From 24-bit mode the three program-counter bytes are saved. From 16-bit mode only the low 16 bits are saved, followed by a zero marker byte, so that a later return can tell the two cases apart. Either way the handler runs in 24-bit mode with both interrupt-enable flags cleared, from the address {00h, handler[15:0]}.

Top module: `vi_entry_seq`

## Requirements
- R1: After reset the memory request, the done pulse, the committed PC, SP and mode outputs and both flag outputs are all 0.
- R2: With the mode bit at 1 when start is accepted, three writes occur in this order: PC[23:16] to SP-1, PC[15:8] to SP-2, PC[7:0] to SP-3, all addresses computed modulo 2^24.
- R3: With the mode bit at 0, the three writes are PC[15:8] to SP-1, PC[7:0] to SP-2, and the marker 00h to SP-3.
- R4: After the writes, two reads follow: the low handler byte from T = {00h, page[7:0], vector[7:0]} and the high byte from T+1 (24-bit sum).
- R5: At completion the PC output is {00h, high byte, low byte}, the SP output is the captured SP minus 3 (modulo 2^24), and the mode output is 1, whatever the entry mode.
- R6: From the edge that accepts start until the done cycle inclusive, both flag outputs read 0. While idle, each flag output follows its flag input one cycle later.
- R7: Each access holds request, address, write enable and write data steady until the acknowledge cycle. Exactly five accesses (three writes, then two reads) are made per entry.
- R8: Done is high for exactly one cycle, and the committed outputs are already updated in that cycle.
- R9: A start pulse while an entry is in progress is ignored: no extra access is made and no second done follows.
- R10: PC, SP, mode, page and vector inputs are sampled only in the start cycle. Later changes do not affect the frame, the table address or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Interrupt accepted, begin entry (one cycle) |
| adl_i | input | 1 | Current addressing mode: 1 = 24-bit, 0 = 16-bit |
| ief1_i | input | 1 | Current interrupt-enable flag 1 |
| ief2_i | input | 1 | Current interrupt-enable flag 2 |
| pc_i | input | 24 | Current program counter |
| sp_i | input | 24 | Current long stack pointer |
| page_i | input | 8 | Vector table page register |
| vect_i | input | 8 | Vector byte from the interrupting peripheral |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 24 | Committed program counter |
| sp_o | output | 24 | Committed stack pointer |
| adl_o | output | 1 | Committed addressing mode |
| ief1_o | output | 1 | Flag 1 value |
| ief2_o | output | 1 | Flag 2 value |

## Verification
The assertions assume that the memory side raises acknowledge only while a request is pending, and only for one cycle per access. They also assume that read data is valid in the acknowledge cycle. The bench's memory model acknowledges only a pending request, after a random wait of zero to two cycles, and drops acknowledge in the following cycle. It returns read data computed from the address. Start pulses come only from idle, or deliberately a few cycles into a running entry, well before completion, so that a pulse never lands in the done cycle where it would legally be accepted.

// File: rtl/vi_pkg.sv
package vi_pkg;
  localparam int ADDR_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_RDLO = 2'd2,
    ST_RDHI = 2'd3
  } vi_state_e;
endpackage

// File: rtl/vi_rst_sync.sv
module vi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/vi_frame_sel.sv
module vi_frame_sel #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          long_mode_i,
  input  logic [AW-1:0] pc_i,
  input  logic [IW-1:0] slot_i,
  output logic [DW-1:0] byte_o
);
  localparam int NS = AW / DW;

  logic [DW-1:0] long_slot  [NS];
  logic [DW-1:0] short_slot [NS];

  // Slot 0 is written first (highest address); the short frame ends with a zero marker.
  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign long_slot[g] = pc_i[AW-1-g*DW -: DW];
    if (g < NS - 1) begin : g_pc
      assign short_slot[g] = pc_i[AW-DW-1-g*DW -: DW];
    end else begin : g_mark
      assign short_slot[g] = '0;
    end
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NS; k++) begin
      if (slot_i == IW'(k)) byte_o = long_mode_i ? long_slot[k] : short_slot[k];
    end
  end
endmodule

// File: rtl/vi_addr_gen.sv
module vi_addr_gen #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic [AW-1:0] sp_i,
  input  logic [IW-1:0] slot_i,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] vect_i,
  input  logic          hi_sel_i,
  output logic [AW-1:0] push_addr_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic [AW-1:0] new_sp_o
);
  localparam int NS   = AW / DW;
  localparam int PADW = AW - 2 * DW;

  logic [AW-1:0] tbl_base;

  assign tbl_base    = {{PADW{1'b0}}, page_i, vect_i};
  assign push_addr_o = sp_i - AW'(slot_i) - AW'(1);
  assign tbl_addr_o  = tbl_base + AW'(hi_sel_i);
  assign new_sp_o    = sp_i - AW'(NS);
endmodule

// File: rtl/vi_mem_if.sv
module vi_mem_if #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          drop_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          req_d, we_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    req_d   = req_o;
    we_d    = we_o;
    addr_d  = addr_o;
    wdata_d = wdata_o;
    if (issue_i) begin
      req_d   = 1'b1;
      we_d    = we_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
    end else if (drop_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (issue_i || drop_i) begin
      req_o   <= req_d;
      we_o    <= we_d;
      addr_o  <= addr_d;
      wdata_o <= wdata_d;
    end
  end

  // R7: a pending access keeps all its fields until acknowledged
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));
endmodule

// File: rtl/vi_entry_seq.sv
module vi_entry_seq import vi_pkg::*; #(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adl_i,
  input  logic          ief1_i,
  input  logic          ief2_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] vect_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          adl_o,
  output logic          ief1_o,
  output logic          ief2_o
);
  localparam int NS   = AW / DW;
  localparam int IW   = $clog2(NS);
  localparam int PADW = AW - 2 * DW;

  logic rst_s_n;

  vi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  vi_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, req_idx;
  logic          cap_en, lo_en, commit, issue, drop, tbl_sel, hi_sel;

  logic [AW-1:0] pc_c, sp_c;
  logic          adl_c;
  logic [DW-1:0] page_c, vect_c, lo_q;

  logic [AW-1:0] src_pc, src_sp;
  logic          src_adl;
  logic [DW-1:0] frame_byte;
  logic [AW-1:0] push_addr, tbl_addr, new_sp;
  logic [AW-1:0] n_addr;
  logic [DW-1:0] n_wdata;
  logic          n_we;
  logic [1:0]    flag_d;

  // In the accept cycle the first write is built straight from the inputs.
  assign src_pc  = (st_q == ST_IDLE) ? pc_i  : pc_c;
  assign src_sp  = (st_q == ST_IDLE) ? sp_i  : sp_c;
  assign src_adl = (st_q == ST_IDLE) ? adl_i : adl_c;
  assign req_idx = (st_q == ST_IDLE) ? '0 : IW'(idx_q + 1'b1);

  vi_frame_sel #(.AW(AW), .DW(DW), .IW(IW)) u_frame (
    .long_mode_i(src_adl),
    .pc_i       (src_pc),
    .slot_i     (req_idx),
    .byte_o     (frame_byte)
  );

  vi_addr_gen #(.AW(AW), .DW(DW), .IW(IW)) u_addr (
    .sp_i       (src_sp),
    .slot_i     (req_idx),
    .page_i     (page_c),
    .vect_i     (vect_c),
    .hi_sel_i   (hi_sel),
    .push_addr_o(push_addr),
    .tbl_addr_o (tbl_addr),
    .new_sp_o   (new_sp)
  );

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    lo_en   = 1'b0;
    commit  = 1'b0;
    issue   = 1'b0;
    drop    = 1'b0;
    tbl_sel = 1'b0;
    hi_sel  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_PUSH;
          idx_d  = '0;
          cap_en = 1'b1;
          issue  = 1'b1;
        end
      end
      ST_PUSH: begin
        if (mem_ack_i) begin
          issue = 1'b1;
          if (idx_q == IW'(NS - 1)) begin
            st_d    = ST_RDLO;
            tbl_sel = 1'b1;
          end else begin
            idx_d = IW'(idx_q + 1'b1);
          end
        end
      end
      ST_RDLO: begin
        if (mem_ack_i) begin
          lo_en   = 1'b1;
          issue   = 1'b1;
          tbl_sel = 1'b1;
          hi_sel  = 1'b1;
          st_d    = ST_RDHI;
        end
      end
      ST_RDHI: begin
        if (mem_ack_i) begin
          drop   = 1'b1;
          commit = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign n_addr  = tbl_sel ? tbl_addr : push_addr;
  assign n_we    = !tbl_sel;
  assign n_wdata = tbl_sel ? '0 : frame_byte;
  assign flag_d  = ((st_q == ST_IDLE) && !start_i) ? {ief1_i, ief2_i} : 2'b00;

  vi_mem_if #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .issue_i(issue),
    .drop_i (drop),
    .we_i   (n_we),
    .addr_i (n_addr),
    .wdata_i(n_wdata),
    .ack_i  (mem_ack_i),
    .req_o  (mem_req_o),
    .we_o   (mem_we_o),
    .addr_o (mem_addr_o),
    .wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pc_c   <= '0;
      sp_c   <= '0;
      adl_c  <= 1'b0;
      page_c <= '0;
      vect_c <= '0;
    end else if (cap_en) begin
      pc_c   <= pc_i;
      sp_c   <= sp_i;
      adl_c  <= adl_i;
      page_c <= page_i;
      vect_c <= vect_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pc_o  <= '0;
      sp_o  <= '0;
      adl_o <= 1'b0;
    end else if (commit) begin
      pc_o  <= {{PADW{1'b0}}, mem_rdata_i, lo_q};
      sp_o  <= new_sp;
      adl_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ief1_o <= 1'b0;
      ief2_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      {ief1_o, ief2_o} <= flag_d;
      done_o           <= commit;
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);
  // R6: flags stay cleared while an entry is in progress
  a_r6_flags_low_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q != ST_IDLE) |-> (!ief1_o && !ief2_o));
  // R5: every completed entry leaves 24-bit mode selected
  a_r5_mode_long: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> adl_o);
  // R1: no request is outstanding while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE) |-> !mem_req_o);
  // R9: committed state moves only on the final acknowledge
  a_r9_no_early_commit: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st_q != ST_RDHI) || !mem_ack_i) |=> ($stable(pc_o) && $stable(sp_o)));
  // R4: the high table byte is fetched from the address after the low one
  a_r4_table_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st_q == ST_RDLO) && mem_ack_i) |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));
endmodule

// File: tb/tb_vi_entry_seq.sv
module tb_vi_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, adl_i, ief1_i, ief2_i;
  logic [23:0] pc_i, sp_i;
  logic [7:0]  page_i, vect_i;
  logic        mem_req_o, mem_we_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_ack_i;
  logic        done_o, adl_o, ief1_o, ief2_o;
  logic [23:0] pc_o, sp_o;

  always #4 clk = ~clk;

  vi_entry_seq dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  // access log filled by the memory model
  logic [23:0] lg_addr [8];
  logic        lg_we   [8];
  logic [7:0]  lg_dat  [8];
  int          lg_n;
  bit          stab_bad;
  bit          prev_wait;
  logic [23:0] p_addr;
  logic        p_we;
  logic [7:0]  p_dat;
  int          wcnt;

  function automatic logic [7:0] rom(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    if (!rst_n) begin
      mem_ack_i = 1'b0;
      wcnt      = 0;
      prev_wait = 1'b0;
    end else begin
      if (mem_req_o && prev_wait &&
          (mem_addr_o != p_addr || mem_we_o != p_we || mem_wdata_o != p_dat))
        stab_bad = 1'b1;
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (wcnt == 0) begin
          mem_ack_i = 1'b1;
          if (lg_n < 8) begin
            lg_addr[lg_n] = mem_addr_o;
            lg_we[lg_n]   = mem_we_o;
            lg_dat[lg_n]  = mem_wdata_o;
          end
          lg_n++;
          mem_rdata_i = mem_we_o ? 8'h00 : rom(mem_addr_o);
          wcnt = $urandom_range(0, 2);
        end else begin
          wcnt--;
        end
      end
      prev_wait = mem_req_o && !mem_ack_i;
      p_addr    = mem_addr_o;
      p_we      = mem_we_o;
      p_dat     = mem_wdata_o;
    end
  end

  task automatic run(input bit adl, input logic [23:0] pc, input logic [23:0] sp,
                     input logic [7:0] pg, input logic [7:0] vc, input bit poke);
    int          cyc;
    bit          flag_bad;
    bit          late_req;
    logic [23:0] t;
    logic [7:0]  ex [3];
    logic [7:0]  f1, f2;
    lg_n     = 0;
    stab_bad = 1'b0;
    @(negedge clk);
    adl_i = adl; pc_i = pc; sp_i = sp; page_i = pg; vect_i = vc;
    ief1_i = 1'b1; ief2_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble sampled inputs after the accept cycle
    pc_i = 24'($urandom); sp_i = 24'($urandom); page_i = 8'($urandom);
    vect_i = 8'($urandom); adl_i = ~adl;
    cyc = 0;
    flag_bad = 1'b0;
    while (!done_o && cyc < 300) begin
      if (ief1_o || ief2_o) flag_bad = 1'b1;
      start_i = (poke && cyc == 2);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk("R8", "done seen before timeout", longint'(cyc < 300), 1);
    if (adl) begin
      ex[0] = pc[23:16]; ex[1] = pc[15:8]; ex[2] = pc[7:0];
    end else begin
      ex[0] = pc[15:8];  ex[1] = pc[7:0];  ex[2] = 8'h00;
    end
    t = {8'h00, pg, vc};
    chk("R7", "access count", lg_n, 5);
    chk("R7", "fields stable while pending", stab_bad, 0);
    for (int k = 0; k < 3; k++) begin
      chk(adl ? "R2" : "R3", "push address", lg_addr[k], 24'(sp - 24'(k + 1)));
      chk(adl ? "R2" : "R3", "push data", lg_dat[k], ex[k]);
      chk("R7", "push is write", lg_we[k], 1);
    end
    chk("R4", "low table addr", lg_addr[3], t);
    chk("R4", "high table addr", lg_addr[4], 24'(t + 24'd1));
    chk("R7", "table reads", {lg_we[3], lg_we[4]}, 0);
    chk("R5", "new pc (R10 inputs held)", pc_o, {8'h00, rom(24'(t + 24'd1)), rom(t)});
    chk("R5", "new sp", sp_o, 24'(sp - 24'd3));
    chk("R5", "mode forced long", adl_o, 1);
    chk("R6", "flags low through entry", {flag_bad, ief1_o, ief2_o}, 0);
    @(negedge clk);
    chk("R8", "done drops after one cycle", done_o, 0);
    f1 = 8'($urandom_range(0, 1)); f2 = 8'($urandom_range(0, 1));
    ief1_i = f1[0]; ief2_i = f2[0];
    late_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (mem_req_o || done_o) late_req = 1'b1;
    end
    chk("R9", "no further activity", {late_req, 3'b0} | lg_n[3:0], 4'd5);
    chk("R6", "flags follow inputs when idle", {ief1_o, ief2_o}, {f1[0], f2[0]});
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; adl_i = 1'b0; ief1_i = 1'b1; ief2_i = 1'b1;
    pc_i = '0; sp_i = '0; page_i = '0; vect_i = '0; mem_rdata_i = '0; mem_ack_i = 1'b0;
    lg_n = 0; stab_bad = 1'b0; prev_wait = 1'b0; wcnt = 0;
    p_addr = '0; p_we = 1'b0; p_dat = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req after reset", mem_req_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "pc/sp after reset", {pc_o, sp_o}, 0);
    chk("R1", "mode and flags after reset", {adl_o, ief1_o, ief2_o}, 0);
    repeat (3) @(negedge clk);

    // directed corners: stack wrap, table carry, both modes, ignored start
    run(1'b1, 24'hABCDEF, 24'h000000, 8'h12, 8'h34, 1'b0);
    run(1'b0, 24'h765432, 24'h000002, 8'hFF, 8'hFF, 1'b0);
    run(1'b1, 24'h010203, 24'h800000, 8'h00, 8'h00, 1'b1);
    run(1'b0, 24'hFFFFFF, 24'hFFFFFF, 8'h40, 8'hFE, 1'b1);

    for (int i = 0; i < 40; i++)
      run(1'($urandom), 24'($urandom), 24'($urandom), 8'($urandom), 8'($urandom),
          1'($urandom));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule